// File: doc/BRIEF.md
# Fixed-Point Compare to Condition Field

This unit carries out the four integer compare operations of a fixed-point pipeline and records the result in one 4-bit field of a 32-bit condition register. Each operation has a primary opcode, an extended opcode, two 64-bit register operands, a 16-bit immediate, a 3-bit field index, a length bit and the current summary-overflow flag. The unit picks the operand width, extends each operand by sign or by zero, orders the pair as signed or unsigned numbers, and merges the encoded result into the selected field. The other seven fields are not touched.

The condition register is held inside the unit and is visible at `cr_o`. An operation is taken on the rising clock edge where `valid_i` is high. There is no back-pressure. The unit accepts one operation on every cycle in which the strobe is high, so no ready signal exists. An operation with an opcode pair the unit does not recognise leaves the register unchanged.

Top module: `cmpcr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `cr_o` to zero.
- R2: Primary opcode 31 with extended opcode 0 is the signed register form. With `len_i`=0, the low 32 bits of both register operands are sign-extended to 64 bits before a signed comparison.
- R3: Primary opcode 31 with extended opcode 32 is the unsigned register form. With `len_i`=0, the upper 32 bits of both register operands are cleared before an unsigned comparison.
- R4: With `len_i`=1, every form compares the full 64-bit register value of `ra_i`. The register forms also use the full 64-bit value of `rb_i`.
- R5: Primary opcode 11 is the signed immediate form. Operand A is treated as in R2 or R4. It is compared, signed, against `imm_i` sign-extended to 64 bits. The extended opcode is ignored.
- R6: Primary opcode 10 is the unsigned immediate form. Operand A is treated as in R3 or R4. It is compared, unsigned, against `imm_i` zero-extended to 64 bits. The extended opcode is ignored.
- R7: The result field is {LT, GT, EQ, SO}, with LT at field bit 3 and SO at field bit 0. LT means A<B, GT means A>B and EQ means A==B, so exactly one of these three bits is set.
- R8: The SO bit of the written field equals `so_i` as sampled at the accepting edge.
- R9: Field k (k = `bf_i`) occupies `cr_o` bits [31-4k : 28-4k], so field 0 is bits 31:28 and field 7 is bits 3:0. No bit outside the selected field changes.
- R10: `cr_o` keeps its value across an edge where `valid_i` is low. It also keeps its value when the opcode pair is not one of the four forms above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe; operands are taken on the edge where it is high |
| opcd_i | input | 6 | Primary opcode |
| xo_i | input | 10 | Extended opcode, used only when the primary opcode is 31 |
| ra_i | input | 64 | Register operand A |
| rb_i | input | 64 | Register operand B, used by the register forms |
| imm_i | input | 16 | Immediate, used by the immediate forms |
| bf_i | input | 3 | Index of the target condition field |
| len_i | input | 1 | 0: compare the extended low 32 bits; 1: compare all 64 bits |
| so_i | input | 1 | Summary-overflow flag copied into the result |
| cr_o | output | 32 | Condition register |

## Verification
The compare logic is combinational and feeds a single register. Every result appears on `cr_o` directly after the rising edge that accepts the operation, with a latency of one edge. The bench drives each operation on a falling edge and holds `valid_i` high for exactly one rising edge. It then samples `cr_o` on the next falling edge and compares it with a model that was updated once for that same edge. Cycles with the strobe low and cycles with an unrecognised opcode are checked in the same slot, to show that the register held its value.

// File: rtl/cmpcr_pkg.sv
package cmpcr_pkg;
  localparam int OPC_W = 6;
  localparam int XO_W  = 10;

  localparam logic [OPC_W-1:0] OPC_XFORM = 6'd31;
  localparam logic [OPC_W-1:0] OPC_SIMM  = 6'd11;
  localparam logic [OPC_W-1:0] OPC_UIMM  = 6'd10;
  localparam logic [XO_W-1:0]  XO_SREG   = 10'd0;
  localparam logic [XO_W-1:0]  XO_UREG   = 10'd32;

  typedef struct packed {
    logic known;
    logic signed_ord;
    logic use_imm;
  } cmp_dec_t;

  function automatic cmp_dec_t cmp_decode(logic [OPC_W-1:0] opc, logic [XO_W-1:0] xo);
    cmp_dec_t d;
    d = '0;
    if (opc == OPC_XFORM && xo == XO_SREG) begin
      d.known = 1'b1; d.signed_ord = 1'b1;
    end else if (opc == OPC_XFORM && xo == XO_UREG) begin
      d.known = 1'b1;
    end else if (opc == OPC_SIMM) begin
      d.known = 1'b1; d.signed_ord = 1'b1; d.use_imm = 1'b1;
    end else if (opc == OPC_UIMM) begin
      d.known = 1'b1; d.use_imm = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/cmp_operand_sel.sv
module cmp_operand_sel #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  ra,
  input  logic [XLEN-1:0]  rb,
  input  logic [IMM_W-1:0] imm,
  input  logic             wide,
  input  logic             signed_ord,
  input  logic             use_imm,
  output logic [XLEN-1:0]  opa,
  output logic [XLEN-1:0]  opb
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] narrow(logic [XLEN-1:0] x, logic sx);
    return {{HALF{sx & x[HALF-1]}}, x[HALF-1:0]};
  endfunction

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext = {{(XLEN-IMM_W){signed_ord & imm[IMM_W-1]}}, imm};
    opa = wide ? ra : narrow(ra, signed_ord);
    if (use_imm)   opb = imm_ext;
    else if (wide) opb = rb;
    else           opb = narrow(rb, signed_ord);
  end
endmodule

// File: rtl/cmp_order.sv
module cmp_order #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            signed_ord,
  output logic            lt,
  output logic            gt,
  output logic            eq
);
  always_comb begin
    eq = (opa == opb);
    if (signed_ord) lt = $signed(opa) < $signed(opb);
    else            lt = opa < opb;
    gt = !lt && !eq;
  end
endmodule

// File: rtl/cr_field_merge.sv
module cr_field_merge #(
  parameter int NFIELDS = 8,
  parameter int FIELD_W = 4,
  localparam int IDX_W  = $clog2(NFIELDS),
  localparam int CR_W   = NFIELDS * FIELD_W
) (
  input  logic [CR_W-1:0]    cr_q,
  input  logic [IDX_W-1:0]   idx,
  input  logic [FIELD_W-1:0] field,
  output logic [CR_W-1:0]    cr_d
);
  for (genvar k = 0; k < NFIELDS; k++) begin : g_field
    assign cr_d[(NFIELDS-1-k)*FIELD_W +: FIELD_W] =
      (idx == IDX_W'(k)) ? field : cr_q[(NFIELDS-1-k)*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/cmpcr_unit.sv
module cmpcr_unit
  import cmpcr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IMM_W   = 16,
  parameter int NFIELDS = 8,
  parameter int FIELD_W = 4,
  localparam int IDX_W  = $clog2(NFIELDS),
  localparam int CR_W   = NFIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [5:0]       opcd_i,
  input  logic [9:0]       xo_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] bf_i,
  input  logic             len_i,
  input  logic             so_i,
  output logic [CR_W-1:0]  cr_o
);
  cmp_dec_t        dec;
  logic [XLEN-1:0] opa, opb;
  logic            lt, gt, eq;
  logic [CR_W-1:0] cr_q, cr_d;

  assign dec = cmp_decode(opcd_i, xo_i);

  cmp_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sel (
    .ra(ra_i), .rb(rb_i), .imm(imm_i), .wide(len_i),
    .signed_ord(dec.signed_ord), .use_imm(dec.use_imm),
    .opa(opa), .opb(opb)
  );

  cmp_order #(.XLEN(XLEN)) u_ord (
    .opa(opa), .opb(opb), .signed_ord(dec.signed_ord),
    .lt(lt), .gt(gt), .eq(eq)
  );

  cr_field_merge #(.NFIELDS(NFIELDS), .FIELD_W(FIELD_W)) u_merge (
    .cr_q(cr_q), .idx(bf_i), .field({lt, gt, eq, so_i}), .cr_d(cr_d)
  );

  always_ff @(posedge clk) begin
    if (rst)                        cr_q <= '0;
    else if (valid_i && dec.known)  cr_q <= cr_d;
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/cmpcr_checker.sv
module cmpcr_checker
  import cmpcr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        valid_i,
  input logic [5:0]  opcd_i,
  input logic [9:0]  xo_i,
  input logic [2:0]  bf_i,
  input logic        so_i,
  input logic [31:0] cr_o
);
  function automatic logic [3:0] fld(logic [31:0] cr, logic [2:0] k);
    return cr[31 - 4*k -: 4];
  endfunction

  function automatic logic [31:0] fmask(logic [2:0] k);
    return 32'hF000_0000 >> (4*k);
  endfunction

  logic take;
  assign take = valid_i && cmp_decode(opcd_i, xo_i).known;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> cr_o == 32'd0);

  assert_one_order_bit_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> $onehot(fld(cr_o, $past(bf_i)) >> 1));

  assert_so_copy_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> fld(cr_o, $past(bf_i))[0] == $past(so_i));

  assert_other_fields_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> ((cr_o ^ $past(cr_o)) & ~fmask($past(bf_i))) == 32'd0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cr_o));
endmodule

bind cmpcr_unit cmpcr_checker u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .opcd_i(opcd_i), .xo_i(xo_i),
  .bf_i(bf_i), .so_i(so_i), .cr_o(cr_o)
);

// File: tb/tb_cmpcr_unit.sv
module tb_cmpcr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [5:0]  opcd_i = '0;
  logic [9:0]  xo_i = '0;
  logic [63:0] ra_i = '0, rb_i = '0;
  logic [15:0] imm_i = '0;
  logic [2:0]  bf_i = '0;
  logic        len_i = 1'b0, so_i = 1'b0;
  logic [31:0] cr_o;

  int checks = 0, failures = 0;
  logic [31:0] model_cr = '0;

  always #5 clk = ~clk;

  cmpcr_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .opcd_i(opcd_i), .xo_i(xo_i),
    .ra_i(ra_i), .rb_i(rb_i), .imm_i(imm_i), .bf_i(bf_i), .len_i(len_i),
    .so_i(so_i), .cr_o(cr_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // form: 0 signed reg, 1 unsigned reg, 2 signed imm, 3 unsigned imm, other unknown
  function automatic int form_of(logic [5:0] op, logic [9:0] xo);
    if (op == 6'd31 && xo == 10'd0)  return 0;
    if (op == 6'd31 && xo == 10'd32) return 1;
    if (op == 6'd11) return 2;
    if (op == 6'd10) return 3;
    return 9;
  endfunction

  function automatic logic [3:0] expect_field(int form, logic [63:0] ra, logic [63:0] rb,
                                             logic [15:0] imm, logic l, logic so);
    longint          sa, sb;
    longint unsigned ua, ub;
    logic lt, gt;
    bit sgn = (form == 0 || form == 2);
    if (l) begin sa = longint'(ra); ua = ra; end
    else begin sa = longint'(int'(ra[31:0])); ua = {32'd0, ra[31:0]}; end
    if (form >= 2) begin
      sb = longint'(shortint'(imm)); ub = {48'd0, imm};
    end else if (l) begin sb = longint'(rb); ub = rb; end
    else begin sb = longint'(int'(rb[31:0])); ub = {32'd0, rb[31:0]}; end
    lt = sgn ? (sa < sb) : (ua < ub);
    gt = sgn ? (sa > sb) : (ua > ub);
    return {lt, gt, !lt && !gt, so};
  endfunction

  task automatic run_op(logic v, logic [5:0] op, logic [9:0] xo, logic [63:0] ra,
                        logic [63:0] rb, logic [15:0] imm, logic [2:0] bf, logic l, logic so);
    int form;
    string tag;
    logic [31:0] m, prev;
    logic [3:0] f;
    @(negedge clk);
    valid_i = v; opcd_i = op; xo_i = xo; ra_i = ra; rb_i = rb;
    imm_i = imm; bf_i = bf; len_i = l; so_i = so;
    form = form_of(op, xo);
    prev = model_cr;
    if (v && form != 9)
      model_cr[31 - 4*bf -: 4] = expect_field(form, ra, rb, imm, l, so);
    @(negedge clk);
    valid_i = 1'b0;
    if (!v || form == 9) begin
      check("R10 hold", cr_o, prev);
    end else begin
      case (form)
        0: tag = l ? "R4 signed reg wide" : "R2 signed reg narrow";
        1: tag = l ? "R4 unsigned reg wide" : "R3 unsigned reg narrow";
        2: tag = "R5 signed imm";
        default: tag = "R6 unsigned imm";
      endcase
      m = 32'hF000_0000 >> (4*bf);
      f = cr_o[31 - 4*bf -: 4];
      check(tag, {28'd0, f}, {28'd0, model_cr[31 - 4*bf -: 4]});
      check("R7 one order bit", {31'd0, $onehot(f[3:1])}, 32'd1);
      check("R8 so copy", {31'd0, f[0]}, {31'd0, so});
      check("R9 other fields", cr_o & ~m, model_cr & ~m);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7131));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset clear", cr_o, 32'd0);

    // directed corners
    run_op(1, 6'd31, 10'd0,  64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000, 16'h0, 3'd0, 0, 0);
    run_op(1, 6'd31, 10'd32, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000, 16'h0, 3'd7, 0, 1);
    run_op(1, 6'd31, 10'd0,  64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000, 16'h0, 3'd3, 1, 0);
    run_op(1, 6'd31, 10'd32, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000, 16'h0, 3'd4, 1, 0);
    run_op(1, 6'd31, 10'd0,  64'h1234_0000_0000_0005, 64'h9999_0000_0000_0005, 16'h0, 3'd1, 0, 0);
    run_op(1, 6'd11, 10'd5,  64'h0000_0000_FFFF_FFFF, 64'h0, 16'hFFFF, 3'd2, 0, 1);
    run_op(1, 6'd10, 10'd0,  64'h0000_0000_0000_FFFF, 64'h0, 16'hFFFF, 3'd5, 0, 0);
    run_op(1, 6'd10, 10'd0,  64'h0000_0000_0000_0001, 64'h0, 16'h8000, 3'd6, 1, 0);
    run_op(1, 6'd11, 10'd0,  64'h8000_0000_0000_0000, 64'h0, 16'h8000, 3'd6, 1, 1);
    run_op(1, 6'd31, 10'd1,  64'h5, 64'h6, 16'h0, 3'd0, 0, 1);
    run_op(1, 6'd12, 10'd0,  64'h5, 64'h6, 16'h0, 3'd7, 0, 1);
    run_op(0, 6'd31, 10'd0,  64'h5, 64'h6, 16'h0, 3'd2, 0, 1);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [63:0] ra, rb;
      logic [15:0] imm;
      logic [5:0] op;
      logic [9:0] xo;
      int sel = int'($urandom_range(0, 9));
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: rb = ra;
        1: rb[31:0] = ra[31:0];
        default: ;
      endcase
      imm = $urandom();
      if ($urandom_range(0, 3) == 0) begin
        imm = ra[15:0];
        ra[63:16] = {48{ra[15]}} & {48{$urandom_range(0, 1) == 1}};
      end
      xo = $urandom();
      case (sel)
        0, 1: begin op = 6'd31; xo = 10'd0; end
        2, 3: begin op = 6'd31; xo = 10'd32; end
        4, 5: op = 6'd11;
        6, 7: op = 6'd10;
        8:    begin op = 6'd31; if (xo == 10'd0 || xo == 10'd32) xo = 10'd1; end
        default: op = ($urandom_range(0, 1) == 1) ? 6'd14 : 6'd9;
      endcase
      run_op($urandom_range(0, 7) != 0, op, xo, ra, rb, imm, 3'($urandom()),
             1'($urandom()), 1'($urandom()));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule